// File: doc/BRIEF.md
# Port Activity Status Formatter

For each of a set of network ports, this block builds the short bit field that a serial LED chain controller drops into its frame. Each port contributes two per-cycle activity strobes, one for transmit and one for receive, plus a 6-bit status word that software writes. A 4-bit format code, shared by all ports, selects which of these items go into the field. The block returns each port's field bits together with the number of valid bits.

Transmit activity means the port is sending packet data or carrier extension. Receive activity means the port has seen a non-idle receive cycle. Such events can last a single cycle, which is far too short to see on an LED. Each port therefore latches any activity into a sticky flag. At every blink-period boundary the flag moves to a displayed copy and is then cleared. The blink period is a count of latch periods: the chain controller pulses `lat_tick` once per latch period, and `blink_rate` gives the number of pulses in one blink period. Frame ordering and the shifting of bits belong to the chain controller.

Ports 0 to 3 form one interface group and ports 4 to 7 form the other. The formatter treats every port the same way.

Top module: `port_status_fmt`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every field's bits and length are zero. The displayed activity flags start cleared.
- R2: Format codes 0x0, 0x1, 0x2 and 0x3 emit only status bits: [0], [1:0], [3:0] and [5:0] respectively. The lengths are 1, 2, 4 and 6. Status bit i sits at field bit i.
- R3: Format codes 0x4, 0x5 and 0x6 place the displayed (TX or RX) flag at field bit 0, followed by status bits [0], [1:0] and [3:0] starting at field bit 1. The lengths are 2, 3 and 5.
- R4: Format codes 0x8, 0x9 and 0xa place the displayed TX flag at field bit 0 and the displayed RX flag at field bit 1, followed by status bits [0], [1:0] and [3:0] starting at field bit 2. The lengths are 3, 4 and 6.
- R5: Format codes 0x7, 0xb, 0xc, 0xd, 0xe and 0xf give length 0 and all-zero bits.
- R6: Field bits at or above the field's length are always zero. Field bit 0 is the first bit in shift order.
- R7: Activity on any cycle of a blink period, including the cycle that carries the closing `lat_tick`, sets the displayed flag for the whole following blink period. If a period has no activity, the flag is clear during the period after it.
- R8: A blink-period boundary falls on every `blink_rate`-th `lat_tick` after reset. A rate of 0 acts as 1, so every tick is a boundary.
- R9: Fields and lengths are registered. A change of format code or status word appears one clock after it is presented. A displayed flag appears one clock after the boundary that sets it.
- R10: Each port's field depends only on that port's own activity strobes and status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lat_tick | input | 1 | One-cycle pulse per latch period |
| blink_rate | input | RATE_W | Latch periods per blink period (0 treated as 1) |
| fmt_code | input | 4 | Field layout code shared by all ports |
| tx_act | input | NUM_PORTS | Per-port transmit activity strobe |
| rx_act | input | NUM_PORTS | Per-port receive activity strobe |
| port_status | input | NUM_PORTS*6 | Software status words, port p at bits [6p+5:6p] |
| field_bits | output | NUM_PORTS*6 | Port p's field at bits [6p+5:6p], bit 6p shifted first |
| field_len | output | NUM_PORTS*3 | Port p's valid bit count at bits [3p+2:3p] |

## Verification
The bench builds the formatter with NUM_PORTS = 2 and RATE_W = 4. With two ports and the blink timer collapsed to one clock, it can sweep every combination of the sixteen format codes, all sixteen patterns of the four activity strobes and all 64 status words. The second port always carries a different status word from the first, so crosstalk between ports shows up as a mismatch. The narrow rate field keeps the stretch tests to a handful of hand-placed ticks. Those tests cover a one-cycle pulse in the middle of a period, activity on the boundary tick itself, the clearing of the flag after an idle period, and a rate of zero.

// File: rtl/psf_pkg.sv
package psf_pkg;
  localparam int STAT_W  = 6;
  localparam int FIELD_W = 6;
  localparam int LEN_W   = $clog2(FIELD_W + 1);

  typedef struct packed {
    logic [FIELD_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } field_t;

  // Build one port's field from the layout code, displayed flags and status.
  function automatic field_t build_field(input logic [3:0] code,
                                         input logic tx, input logic rx,
                                         input logic [STAT_W-1:0] st);
    field_t f;
    logic [7:0] nst, npre, pre, keep, sh, tot;
    logic ok;
    case (code[1:0])
      2'd0:    nst = 8'd1;
      2'd1:    nst = 8'd2;
      2'd2:    nst = 8'd4;
      default: nst = 8'd6;
    endcase
    ok = 1'b1;
    pre = 8'd0;
    npre = 8'd0;
    case (code[3:2])
      2'd0: ;
      2'd1: begin
        pre = {7'd0, tx | rx};
        npre = 8'd1;
        ok = (code[1:0] != 2'd3);
      end
      2'd2: begin
        pre = {6'd0, rx, tx};
        npre = 8'd2;
        ok = (code[1:0] != 2'd3);
      end
      default: ok = 1'b0;
    endcase
    keep = (8'd1 << nst) - 8'd1;
    sh   = ((8'(st) & keep) << npre) | pre;
    tot  = npre + nst;
    if (ok) begin
      f.bits = sh[FIELD_W-1:0];
      f.len  = tot[LEN_W-1:0];
    end else begin
      f = '0;
    end
    return f;
  endfunction
endpackage

// File: rtl/psf_blink_timer.sv
module psf_blink_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat_tick,
  input  logic [RATE_W-1:0] rate,
  output logic              boundary
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W:0]   nxt;

  assign nxt      = {1'b0, cnt} + 1'b1;
  assign boundary = lat_tick && (nxt >= {1'b0, rate});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (lat_tick) begin
      cnt <= boundary ? '0 : nxt[RATE_W-1:0];
    end
  end
endmodule

// File: rtl/psf_act_hold.sv
module psf_act_hold (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic act_in,
  output logic act_shown
);
  logic sticky;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky    <= 1'b0;
      act_shown <= 1'b0;
    end else if (boundary) begin
      act_shown <= sticky | act_in;
      sticky    <= 1'b0;
    end else begin
      sticky <= sticky | act_in;
    end
  end
endmodule

// File: rtl/psf_port_fmt.sv
module psf_port_fmt
  import psf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         code,
  input  logic               tx_shown,
  input  logic               rx_shown,
  input  logic [STAT_W-1:0]  status,
  output logic [FIELD_W-1:0] bits,
  output logic [LEN_W-1:0]   len
);
  field_t nxt;

  always_comb nxt = build_field(code, tx_shown, rx_shown, status);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
      len  <= '0;
    end else begin
      bits <= nxt.bits;
      len  <= nxt.len;
    end
  end
endmodule

// File: rtl/port_status_fmt.sv
module port_status_fmt
  import psf_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int RATE_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lat_tick,
  input  logic [RATE_W-1:0]            blink_rate,
  input  logic [3:0]                   fmt_code,
  input  logic [NUM_PORTS-1:0]         tx_act,
  input  logic [NUM_PORTS-1:0]         rx_act,
  input  logic [NUM_PORTS*STAT_W-1:0]  port_status,
  output logic [NUM_PORTS*FIELD_W-1:0] field_bits,
  output logic [NUM_PORTS*LEN_W-1:0]   field_len
);
  logic                 boundary;
  logic [NUM_PORTS-1:0] tx_shown;
  logic [NUM_PORTS-1:0] rx_shown;

  psf_blink_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst(rst), .lat_tick(lat_tick),
    .rate(blink_rate), .boundary(boundary)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    psf_act_hold u_tx_hold (
      .clk(clk), .rst(rst), .boundary(boundary),
      .act_in(tx_act[p]), .act_shown(tx_shown[p])
    );
    psf_act_hold u_rx_hold (
      .clk(clk), .rst(rst), .boundary(boundary),
      .act_in(rx_act[p]), .act_shown(rx_shown[p])
    );
    psf_port_fmt u_fmt (
      .clk(clk), .rst(rst), .code(fmt_code),
      .tx_shown(tx_shown[p]), .rx_shown(rx_shown[p]),
      .status(port_status[p*STAT_W +: STAT_W]),
      .bits(field_bits[p*FIELD_W +: FIELD_W]),
      .len(field_len[p*LEN_W +: LEN_W])
    );
  end
endmodule

// File: rtl/psf_checker.sv
module psf_checker
  import psf_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [3:0]                   fmt_code,
  input logic [NUM_PORTS*STAT_W-1:0]  port_status,
  input logic [NUM_PORTS*FIELD_W-1:0] field_bits,
  input logic [NUM_PORTS*LEN_W-1:0]   field_len
);
  logic unused_code;
  assign unused_code = (fmt_code[1:0] == 2'd3 && fmt_code[3:2] != 2'd0) || (fmt_code[3:2] == 2'd3);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (field_len == '0 && field_bits == '0));

  // R5
  unused_len_chk: assert property (@(posedge clk) disable iff (rst)
    unused_code |=> (field_len == '0 && field_bits == '0));

  // R9
  status_only_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fmt_code[3:2] == 2'd0 && $stable(fmt_code) && $stable(port_status))
      |=> $stable(field_bits));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (field_bits[p*FIELD_W +: FIELD_W] >> field_len[p*LEN_W +: LEN_W]) == '0);
    // R2
    full_status_chk: assert property (@(posedge clk) disable iff (rst)
      fmt_code == 4'h3 |=> (field_len[p*LEN_W +: LEN_W] == LEN_W'(6) &&
        field_bits[p*FIELD_W +: FIELD_W] == $past(port_status[p*STAT_W +: STAT_W])));
  end
endmodule

bind port_status_fmt psf_checker #(.NUM_PORTS(NUM_PORTS)) u_psf_checker (
  .clk(clk), .rst(rst), .fmt_code(fmt_code), .port_status(port_status),
  .field_bits(field_bits), .field_len(field_len)
);

// File: tb/test_port_status_fmt.sv
`timescale 1ns/1ps
module test_port_status_fmt;
  localparam int NP = 2;
  localparam int RW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            lat_tick = 1'b0;
  logic [RW-1:0]   blink_rate = '0;
  logic [3:0]      fmt_code = '0;
  logic [NP-1:0]   tx_act = '0;
  logic [NP-1:0]   rx_act = '0;
  logic [NP*6-1:0] port_status = '0;
  logic [NP*6-1:0] field_bits;
  logic [NP*3-1:0] field_len;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  port_status_fmt #(.NUM_PORTS(NP), .RATE_W(RW)) i_port_status_fmt (
    .clk(clk), .rst(rst), .lat_tick(lat_tick), .blink_rate(blink_rate),
    .fmt_code(fmt_code), .tx_act(tx_act), .rx_act(rx_act),
    .port_status(port_status), .field_bits(field_bits), .field_len(field_len)
  );

  always #4 clk = ~clk;

  // Expected field: items appended one at a time from bit 0 upward.
  task automatic model(input logic [3:0] code, input logic tx, input logic rx,
                       input logic [5:0] st, output logic [5:0] eb, output logic [2:0] el);
    int pos = 0;
    int n;
    bit ok;
    eb = '0;
    ok = (code <= 4'h6 && code != 4'h3) || code == 4'h3 || (code >= 4'h8 && code <= 4'ha);
    n = (code % 4 == 0) ? 1 : (code % 4 == 1) ? 2 : (code % 4 == 2) ? 4 : 6;
    if (code >= 4'h4 && code <= 4'h6) begin eb[pos] = tx | rx; pos++; end
    if (code >= 4'h8 && code <= 4'ha) begin eb[pos] = tx; pos++; eb[pos] = rx; pos++; end
    for (int i = 0; i < n; i++) begin eb[pos] = st[i]; pos++; end
    el = 3'(pos);
    if (!ok) begin eb = '0; el = '0; end
  endtask

  task automatic check(input string tag, input int p, input logic [5:0] eb, input logic [2:0] el);
    logic [5:0] ab;
    logic [2:0] al;
    ab = field_bits[p*6 +: 6];
    al = field_len[p*3 +: 3];
    checks++;
    if (ab !== eb || al !== el) begin
      fails++;
      $display("FAIL %s port %0d: bits=%b len=%0d expected bits=%b len=%0d", tag, p, ab, al, eb, el);
    end
  endtask

  task automatic tick(input logic tx0, input logic rx0);
    @(negedge clk);
    lat_tick = 1'b1; tx_act[0] = tx0; rx_act[0] = rx0;
    @(negedge clk);
    lat_tick = 1'b0; tx_act[0] = 1'b0; rx_act[0] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [5:0] eb;
    logic [2:0] el;
    string tag;

    // R1: outputs clear during and right after reset
    repeat (3) @(negedge clk);
    check("R1", 0, 6'd0, 3'd0);
    rst = 1'b0;
    port_status = 12'hFFF; fmt_code = 4'h3;
    #1 check("R1", 1, 6'd0, 3'd0);

    // Exhaustive layout sweep, boundary every clock (rate 1, tick held high)
    blink_rate = 4'd1; lat_tick = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int s = 0; s < 64; s++) begin
          @(negedge clk);
          fmt_code = 4'(c);
          tx_act = {a[2], a[0]};
          rx_act = {a[3], a[1]};
          port_status = {6'(s * 5 + 17), 6'(s)};
          @(posedge clk); @(posedge clk); @(negedge clk);
          tag = (c <= 3) ? "R2/R6" : (c <= 6) ? "R3/R6" : (c >= 8 && c <= 10) ? "R4/R6" : "R5/R6";
          model(4'(c), a[0], a[1], 6'(s), eb, el);
          check(tag, 0, eb, el);
          model(4'(c), a[2], a[3], 6'(s * 5 + 17), eb, el);
          check({tag, "/R10"}, 1, eb, el);
        end
      end
    end

    // R9: registered latency of a status change
    @(negedge clk);
    tx_act = '0; rx_act = '0; fmt_code = 4'h3; port_status = {6'h00, 6'h15};
    @(negedge clk);
    port_status = {6'h00, 6'h2a};
    #1 check("R9", 0, 6'h15, 3'd6);
    @(negedge clk);
    check("R9", 0, 6'h2a, 3'd6);

    // R7/R8: stretch with rate 3, layout 0x8 (tx bit0, rx bit1, status bit2)
    lat_tick = 1'b0;
    do_reset();
    blink_rate = 4'd3; fmt_code = 4'h8; port_status = '0;
    tick(1'b0, 1'b0);
    @(negedge clk); tx_act[0] = 1'b1;
    @(negedge clk); tx_act[0] = 1'b0;
    tick(1'b0, 1'b0);
    @(negedge clk);
    check("R8 before boundary", 0, 6'b000000, 3'd3);
    tick(1'b0, 1'b0);
    @(negedge clk);
    check("R7 pulse shown", 0, 6'b000001, 3'd3);
    check("R10 other port", 1, 6'b000000, 3'd3);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    @(negedge clk);
    check("R7 held whole period", 0, 6'b000001, 3'd3);
    tick(1'b0, 1'b1);
    @(negedge clk);
    check("R7 idle clears tx, rx on boundary tick", 0, 6'b000010, 3'd3);
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    @(negedge clk);
    check("R7 rx cleared after idle period", 0, 6'b000000, 3'd3);

    // R8: rate 0 acts as 1
    do_reset();
    blink_rate = 4'd0; fmt_code = 4'h4;
    tick(1'b1, 1'b0);
    @(negedge clk);
    check("R8 rate zero", 0, 6'b000001, 3'd2);
    tick(1'b0, 1'b0);
    @(negedge clk);
    check("R8 rate zero next tick", 0, 6'b000000, 3'd2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule